// File: doc/BRIEF.md
# PCM Frame Timing Counter

This block produces the bit and time-slot timing of a serial PCM highway. It watches an external data clock and an external framing pulse, both of which it samples in the system clock domain. It keeps a bit position within the frame, and from that position it drives the current slot number, the bit index inside the slot, a transmit strobe, a sample strobe and an output enable for the PCM data pins. Serialisers and slot-switching memories elsewhere in the chip use these outputs to decide when to shift a bit out and when to capture a bit in.

The frame holds between 4 and 128 eight-bit slots. The data clock runs either at the bit rate or at twice the bit rate. Each of the following is selected on its own by a configuration pin: the clock edge that latches the framing pulse, the edge that launches transmit data, and the edge that samples receive data. A bit offset sets which bit of the external frame the framing pulse marks. A standby pin turns the data pin drivers off and leaves counting untouched.

All pins are plain control and status lines. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `pcm_frame_timer`

## Requirements
- R1: The effective slot count is `cfg_slots_i` clamped to the range 4..128. The frame length is that count times 8 bits, and the bit position wraps from frame length − 1 to 0.
- R2: `slot_o` is the bit position divided by 8, and `bit_o` is the position modulo 8, with 0 being the first bit of the slot. After reset both are 0, both strobes are low, and the position runs freely from 0 until the first framing event.
- R3: A framing event is a 0→1 change of the latched framing pulse. It loads the position with `cfg_offset_i` and clears the double-rate phase. This happens at the first rising data-clock edge at or after the latching edge. A pulse held high causes no further loads.
- R4: `cfg_fs_edge_i` = 0 latches the framing pulse on rising data-clock edges. A value of 1 latches it on falling edges.
- R5: In single rate (`cfg_double_i` = 0) the position advances by one on every rising data-clock edge. Each data-clock period gives exactly one transmit strobe and one sample strobe.
- R6: In double rate (`cfg_double_i` = 1) each bit spans two data-clock periods, phase 0 then phase 1, and the position advances every second rising edge. Transmit strobes occur only in phase-0 periods and sample strobes only in phase-1 periods.
- R7: `cfg_tx_edge_i` = 0 puts the transmit strobe on the rising edge of its period. A value of 1 puts it on the falling edge.
- R8: `cfg_rx_edge_i` = 0 puts the sample strobe on the rising edge of its period. A value of 1 puts it on the falling edge.
- R9: `pcm_oe_o` is low during reset. Afterwards it equals the inverse of `cfg_standby_i` one clock later. Standby has no effect on the position or on the strobes.
- R10: Any offset from 0 to frame length − 1 is loaded as given. Counting continues from that value and wraps across the frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcm_clk_i | input | 1 | External PCM data clock |
| frame_sync_i | input | 1 | External framing pulse |
| cfg_slots_i | input | 8 | Slots per frame (clamped to 4..128) |
| cfg_double_i | input | 1 | 1 = data clock at twice the bit rate |
| cfg_fs_edge_i | input | 1 | Framing latch edge, 0 rising / 1 falling |
| cfg_tx_edge_i | input | 1 | Transmit strobe edge, 0 rising / 1 falling |
| cfg_rx_edge_i | input | 1 | Sample strobe edge, 0 rising / 1 falling |
| cfg_offset_i | input | 10 | Bit position loaded on a framing event |
| cfg_standby_i | input | 1 | 1 = PCM data drivers off |
| slot_o | output | 7 | Current time slot |
| bit_o | output | 3 | Bit index inside the slot |
| tx_stb_o | output | 1 | One-clock transmit strobe |
| rx_stb_o | output | 1 | One-clock sample strobe |
| pcm_oe_o | output | 1 | Output enable for the PCM data pins |

## Verification
A data-clock edge on the pin reaches the position and the strobes three system clocks later: two synchroniser flops, then the counter and strobe registers. The output enable follows standby after a single clock. The bench holds each data-clock level for seven clocks and changes the framing pulse only in the middle of a half period. It reads the slot and bit at the very end of each period, and it counts strobes separately in the high half and the low half. Every sample therefore falls well after the three-clock latency and before the next edge can take effect.

// File: rtl/pcm_ft_pkg.sv
package pcm_ft_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } pcm_edge_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } clk_evt_t;

  // Select the edge event matching a configured edge.
  function automatic logic pick_edge(input pcm_edge_e sel, input clk_evt_t ev);
    return (sel == EDGE_FALL) ? ev.fall : ev.rise;
  endfunction

endpackage

// File: rtl/pcm_ft_edges.sv
module pcm_ft_edges
  import pcm_ft_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pcm_clk_i,
  input  logic     fs_i,
  output clk_evt_t ev_o,
  output logic     fs_o
);

  logic [STAGES-1:0] clk_sh;
  logic [STAGES-1:0] fs_sh;
  logic              clk_prev;

  // Synchroniser chains; the framing pulse goes through the same depth
  // so it stays aligned with the clock edge events.
  for (genvar i = 0; i < STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          clk_sh[0] <= 1'b0;
          fs_sh[0]  <= 1'b0;
        end else begin
          clk_sh[0] <= pcm_clk_i;
          fs_sh[0]  <= fs_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          clk_sh[i] <= 1'b0;
          fs_sh[i]  <= 1'b0;
        end else begin
          clk_sh[i] <= clk_sh[i-1];
          fs_sh[i]  <= fs_sh[i-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 1'b0;
    else        clk_prev <= clk_sh[STAGES-1];
  end

  always_comb begin
    ev_o.rise = clk_sh[STAGES-1] & ~clk_prev;
    ev_o.fall = ~clk_sh[STAGES-1] & clk_prev;
    fs_o      = fs_sh[STAGES-1];
  end

endmodule

// File: rtl/pcm_ft_frame_detect.sv
module pcm_ft_frame_detect
  import pcm_ft_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  clk_evt_t  ev_i,
  input  logic      fs_i,
  input  pcm_edge_e latch_sel_i,
  output logic      load_o
);

  logic fs_lat;
  logic pend;
  logic lat_stb;
  logic fs_evt;

  always_comb begin
    lat_stb = pick_edge(latch_sel_i, ev_i);
    fs_evt  = lat_stb & fs_i & ~fs_lat;
    // A framing event seen on a rising edge loads at once; one seen on a
    // falling edge waits for the next rising edge.
    load_o  = ev_i.rise & (pend | (fs_evt & (latch_sel_i == EDGE_RISE)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_lat <= 1'b0;
      pend   <= 1'b0;
    end else begin
      if (lat_stb) fs_lat <= fs_i;
      if (ev_i.rise)   pend <= 1'b0;
      else if (fs_evt) pend <= 1'b1;
    end
  end

endmodule

// File: rtl/pcm_ft_counter.sv
module pcm_ft_counter #(
  parameter int MAX_SLOTS = 128,
  parameter int MIN_SLOTS = 4,
  parameter int SLOT_BITS = 8,
  localparam int POS_W = $clog2(MAX_SLOTS * SLOT_BITS),
  localparam int LEN_W = POS_W + 1,
  localparam int CNT_W = $clog2(MAX_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] slots_i,
  input  logic             double_i,
  input  logic [POS_W-1:0] offset_i,
  input  logic             rise_i,
  input  logic             load_i,
  output logic [POS_W-1:0] pos_o,
  output logic [LEN_W-1:0] len_o,
  output logic             phase_o
);

  logic [CNT_W-1:0] slots_eff;
  logic [POS_W-1:0] pos_q, pos_nx, pos_inc;
  logic             ph_q, ph_nx;

  always_comb begin
    if (slots_i < CNT_W'(MIN_SLOTS))      slots_eff = CNT_W'(MIN_SLOTS);
    else if (slots_i > CNT_W'(MAX_SLOTS)) slots_eff = CNT_W'(MAX_SLOTS);
    else                                  slots_eff = slots_i;
    len_o = LEN_W'(slots_eff) * LEN_W'(SLOT_BITS);
  end

  always_comb begin
    if ({1'b0, pos_q} >= len_o - LEN_W'(1)) pos_inc = '0;
    else                                    pos_inc = pos_q + POS_W'(1);

    pos_nx = pos_q;
    ph_nx  = ph_q;
    if (rise_i) begin
      if (load_i) begin
        pos_nx = offset_i;
        ph_nx  = 1'b0;
      end else if (double_i) begin
        ph_nx = ~ph_q;
        if (ph_q) pos_nx = pos_inc;
      end else begin
        pos_nx = pos_inc;
        ph_nx  = 1'b0;
      end
    end
    // Phase of the data-clock period the current edge belongs to.
    phase_o = rise_i ? ph_nx : ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      pos_q <= pos_nx;
      ph_q  <= ph_nx;
    end
  end

  assign pos_o = pos_q;

endmodule

// File: rtl/pcm_ft_strobes.sv
module pcm_ft_strobes
  import pcm_ft_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  clk_evt_t  ev_i,
  input  logic      double_i,
  input  logic      phase_i,
  input  pcm_edge_e tx_sel_i,
  input  pcm_edge_e rx_sel_i,
  input  logic      standby_i,
  output logic      tx_stb_o,
  output logic      rx_stb_o,
  output logic      oe_o
);

  logic tx_hit, rx_hit;

  always_comb begin
    tx_hit = pick_edge(tx_sel_i, ev_i) & (~double_i | ~phase_i);
    rx_hit = pick_edge(rx_sel_i, ev_i) & (~double_i | phase_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_stb_o <= 1'b0;
      rx_stb_o <= 1'b0;
      oe_o     <= 1'b0;
    end else begin
      tx_stb_o <= tx_hit;
      rx_stb_o <= rx_hit;
      oe_o     <= ~standby_i;
    end
  end

endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_ft_pkg::*;
#(
  parameter int MAX_SLOTS   = 128,
  parameter int SLOT_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int POS_W  = $clog2(MAX_SLOTS * SLOT_BITS),
  localparam int LEN_W  = POS_W + 1,
  localparam int CNT_W  = $clog2(MAX_SLOTS + 1),
  localparam int BIT_W  = $clog2(SLOT_BITS),
  localparam int SLOT_W = POS_W - BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pcm_clk_i,
  input  logic              frame_sync_i,
  input  logic [CNT_W-1:0]  cfg_slots_i,
  input  logic              cfg_double_i,
  input  logic              cfg_fs_edge_i,
  input  logic              cfg_tx_edge_i,
  input  logic              cfg_rx_edge_i,
  input  logic [POS_W-1:0]  cfg_offset_i,
  input  logic              cfg_standby_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              tx_stb_o,
  output logic              rx_stb_o,
  output logic              pcm_oe_o
);

  clk_evt_t         clk_ev;
  logic             fs_lvl;
  logic             load_w;
  logic [POS_W-1:0] pos_w;
  logic [LEN_W-1:0] len_w;
  logic             phase_w;

  pcm_ft_edges #(.STAGES(SYNC_STAGES)) u_edges (
    .clk       (clk),
    .rst_n     (rst_n),
    .pcm_clk_i (pcm_clk_i),
    .fs_i      (frame_sync_i),
    .ev_o      (clk_ev),
    .fs_o      (fs_lvl)
  );

  pcm_ft_frame_detect u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_i        (clk_ev),
    .fs_i        (fs_lvl),
    .latch_sel_i (pcm_edge_e'(cfg_fs_edge_i)),
    .load_o      (load_w)
  );

  pcm_ft_counter #(
    .MAX_SLOTS (MAX_SLOTS),
    .SLOT_BITS (SLOT_BITS)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .slots_i  (cfg_slots_i),
    .double_i (cfg_double_i),
    .offset_i (cfg_offset_i),
    .rise_i   (clk_ev.rise),
    .load_i   (load_w),
    .pos_o    (pos_w),
    .len_o    (len_w),
    .phase_o  (phase_w)
  );

  pcm_ft_strobes u_stb (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_i      (clk_ev),
    .double_i  (cfg_double_i),
    .phase_i   (phase_w),
    .tx_sel_i  (pcm_edge_e'(cfg_tx_edge_i)),
    .rx_sel_i  (pcm_edge_e'(cfg_rx_edge_i)),
    .standby_i (cfg_standby_i),
    .tx_stb_o  (tx_stb_o),
    .rx_stb_o  (rx_stb_o),
    .oe_o      (pcm_oe_o)
  );

  assign slot_o = pos_w[POS_W-1:BIT_W];
  assign bit_o  = pos_w[BIT_W-1:0];

endmodule

// File: rtl/pcm_frame_timer_chk.sv
module pcm_frame_timer_chk #(
  parameter int POS_W = 10,
  localparam int LEN_W = POS_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_double_i,
  input logic             cfg_standby_i,
  input logic [POS_W-1:0] cfg_offset_i,
  input logic             rise_i,
  input logic             load_i,
  input logic [POS_W-1:0] pos_i,
  input logic [LEN_W-1:0] len_i,
  input logic             tx_stb_i,
  input logic             rx_stb_i,
  input logic             oe_i
);

  a_r9_oe_follows_standby: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> oe_i == !$past(cfg_standby_i));

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_double_i && $past(cfg_double_i) && tx_stb_i) |-> !rx_stb_i);

  a_r3_load_takes_offset: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> pos_i == $past(cfg_offset_i));

  a_r5_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_i |=> pos_i == $past(pos_i));

  a_r5_single_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !load_i && !cfg_double_i && ({1'b0, pos_i} < len_i - LEN_W'(1)))
      |=> pos_i == $past(pos_i) + POS_W'(1));

endmodule

bind pcm_frame_timer pcm_frame_timer_chk #(.POS_W(POS_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_double_i  (cfg_double_i),
  .cfg_standby_i (cfg_standby_i),
  .cfg_offset_i  (cfg_offset_i),
  .rise_i        (clk_ev.rise),
  .load_i        (load_w),
  .pos_i         (pos_w),
  .len_i         (len_w),
  .tx_stb_i      (tx_stb_o),
  .rx_stb_i      (rx_stb_o),
  .oe_i          (pcm_oe_o)
);

// File: tb/pcm_frame_timer_tb_top.sv
`timescale 1ns/1ps
module pcm_frame_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pcm_clk = 1'b0;
  logic       fs = 1'b0;
  logic [7:0] cfg_slots = 8'd32;
  logic       cfg_double = 1'b0;
  logic       cfg_fs_edge = 1'b0;
  logic       cfg_tx_edge = 1'b0;
  logic       cfg_rx_edge = 1'b1;
  logic [9:0] cfg_offset = '0;
  logic       cfg_standby = 1'b0;
  logic [6:0] slot;
  logic [2:0] bitx;
  logic       tx_stb, rx_stb, oe;

  always #5 clk = ~clk;

  pcm_frame_timer dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pcm_clk_i     (pcm_clk),
    .frame_sync_i  (fs),
    .cfg_slots_i   (cfg_slots),
    .cfg_double_i  (cfg_double),
    .cfg_fs_edge_i (cfg_fs_edge),
    .cfg_tx_edge_i (cfg_tx_edge),
    .cfg_rx_edge_i (cfg_rx_edge),
    .cfg_offset_i  (cfg_offset),
    .cfg_standby_i (cfg_standby),
    .slot_o        (slot),
    .bit_o         (bitx),
    .tx_stb_o      (tx_stb),
    .rx_stb_o      (rx_stb),
    .pcm_oe_o      (oe)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int tx_cnt = 0, rx_cnt = 0;
  int tx_h, rx_h, tx_l, rx_l, got_slot, got_bit, got_oe;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (tx_stb) tx_cnt++;
    if (rx_stb) rx_cnt++;
  end

  task automatic chk(input string req, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int clampv(input int s);
    if (s < 4)   return 4;
    if (s > 128) return 128;
    return s;
  endfunction

  // One data-clock half period; the framing pulse moves mid-half.
  task automatic half(input logic lvl, input logic fsv);
    @(posedge clk); #1;
    if (lvl) begin tx_cnt = 0; rx_cnt = 0; end
    pcm_clk = lvl;
    repeat (3) @(posedge clk);
    #1 fs = fsv;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic period(input logic fs_hi, input logic fs_lo);
    half(1'b1, fs_hi);
    tx_h = tx_cnt; rx_h = rx_cnt;
    half(1'b0, fs_lo);
    tx_l = tx_cnt - tx_h; rx_l = rx_cnt - rx_h;
    got_slot = int'(slot); got_bit = int'(bitx); got_oe = int'(oe);
  endtask

  task automatic run_frame(input int slots, input bit dbl, input bit fse,
                           input bit txe, input bit rxe, input int off,
                           input bit sb, input bit hold, input int nper,
                           input string tag);
    int len, pos, ph, etx, erx;
    len = clampv(slots) * 8;
    cfg_slots = 8'(slots); cfg_double = dbl; cfg_fs_edge = fse;
    cfg_tx_edge = txe; cfg_rx_edge = rxe; cfg_offset = 10'(off);
    cfg_standby = sb;
    period(1'b0, 1'b0);
    period(1'b0, 1'b0);
    // R4: pulse placed so only the selected latch edge catches it first
    if (!fse) period(1'b0, 1'b1);
    else      period(1'b1, hold);
    for (int j = 0; j < nper; j++) begin
      period(hold, hold);
      pos = (off + (dbl ? j / 2 : j)) % len;
      ph  = dbl ? j % 2 : 0;
      chk({tag, " slot"}, got_slot, pos / 8);
      chk({tag, " bit"},  got_bit,  pos % 8);
      etx = (!dbl || ph == 0) ? 1 : 0;
      erx = (!dbl || ph == 1) ? 1 : 0;
      chk("R7 tx strobe high half", tx_h, txe ? 0 : etx);
      chk("R7 tx strobe low half",  tx_l, txe ? etx : 0);
      chk("R8 rx strobe high half", rx_h, rxe ? 0 : erx);
      chk("R8 rx strobe low half",  rx_l, rxe ? erx : 0);
      chk("R9 output enable", got_oe, sb ? 0 : 1);
    end
  endtask

  initial begin
    int unsigned sd;
    int s, len, off;
    bit dbl;
    sd = $urandom(32'd20250);
    repeat (3) @(posedge clk);
    #1;
    chk("R9 oe low in reset", int'(oe), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R2 reset slot", int'(slot), 0);
    chk("R2 reset bit", int'(bitx), 0);
    chk("R2 reset tx strobe", int'(tx_stb), 0);
    chk("R2 reset rx strobe", int'(rx_stb), 0);
    chk("R9 oe after reset", int'(oe), 1);

    // Directed corners
    run_frame(32, 1'b0, 1'b0, 1'b0, 1'b1, 5, 1'b0, 1'b0, 12, "R5");
    run_frame(2, 1'b0, 1'b1, 1'b1, 1'b0, 30, 1'b0, 1'b0, 6, "R1 low clamp");
    run_frame(250, 1'b0, 1'b0, 1'b0, 1'b0, 1021, 1'b0, 1'b0, 6, "R1 high clamp");
    run_frame(4, 1'b1, 1'b1, 1'b0, 1'b1, 31, 1'b0, 1'b0, 8, "R6 wrap");
    run_frame(16, 1'b1, 1'b0, 1'b1, 1'b0, 0, 1'b1, 1'b0, 8, "R9 standby count");
    run_frame(8, 1'b0, 1'b0, 1'b0, 1'b1, 60, 1'b0, 1'b1, 10, "R3 held pulse");
    run_frame(8, 1'b1, 1'b1, 1'b1, 1'b1, 62, 1'b0, 1'b1, 10, "R3 held pulse");
    run_frame(128, 1'b0, 1'b1, 1'b0, 1'b1, 1023, 1'b0, 1'b0, 4, "R10 last bit");

    // Constrained random trials
    for (int t = 0; t < 30; t++) begin
      s   = 4 + int'($urandom % 125);
      len = s * 8;
      off = ($urandom % 2 == 0) ? int'($urandom % len) : len - 1 - int'($urandom % 3);
      dbl = 1'($urandom);
      run_frame(s, dbl, 1'($urandom), 1'($urandom), 1'($urandom), off,
                1'($urandom % 4 == 0), 1'($urandom % 4 == 0), 16,
                dbl ? "R6 R10 random" : "R5 R10 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule